// File: doc/BRIEF.md
# Synchronous Serial Word Transmitter

This block is the sending half of a clocked serial port. Software writes a word into a one-entry transmit buffer. The block shifts each word out on a data line, most significant bit first, in step with a shift clock. The shift clock comes from one of two sources. It can be made inside the block from the system clock by a fixed divider, in which case it is driven out on `sck_out`. It can also come from an external master on `sck_in`; that input passes through a two-flop synchroniser and an edge detector.

If the next word is written before the current one ends, the words leave back to back with no gap. When the buffer is empty at a word boundary, the result depends on the clock source:
- With the internal clock, the block parks the clock high and waits for data.
- With an external clock, the block cannot hold the master back. It sends all ones, flags an underrun and requests an interrupt.

Software can stop the block in two ways. A graceful stop finishes the word in progress. A forced stop halts at once and clears the control, status and buffer state.

Registers (address on `wr_addr`/`rd_addr`):
- 0, control: bit 0 run, bit 1 force stop (self-clearing, reads 0), bit 2 external clock.
- 1, status: bit 0 buffer empty, bit 1 busy, bit 2 shift in progress, bit 3 underrun error.
- 2, transmit buffer.

Top module: `sync_ser_tx`

## Requirements
- R1: With the internal clock, each word goes out as 8 bits, most significant bit first. Data changes with the falling edge of `sck_out` and is sampled on its rising edge.
- R2: After reset, status reads 0x01. A write to address 2 clears status bit 0 (buffer empty) from the next cycle. The bit returns to 1 when the word is moved into the shifter.
- R3: A word written while the previous one is still shifting follows it with no gap. Successive rising edges of `sck_out` stay exactly 2*DIV system cycles apart across the word boundary.
- R4: With the internal clock, if the buffer is empty when a word ends, the following hold until new data arrives: `sck_out` and `sd_out` stay high, busy stays 1 and shift-in-progress reads 0.
- R5: A write during that wait makes `sck_out` fall within DIV system cycles of the write, and the new word is then sent.
- R6: With the external clock, a word boundary that meets an empty buffer does three things: sends all ones, sets status bit 3, and raises `irq`.
- R7: Clearing the run bit lets the word in progress finish. The block then clears busy and holds both lines high. It sends nothing more, even if a word is waiting in the buffer.
- R8: Writing 1 to control bit 1 stops shifting on the next cycle with both lines high. It also clears run, the status flags (status reads 0x01) and the transmit buffer (reads 0x00).
- R9: `irq` is a one-cycle pulse, raised once each time a word is taken from the buffer and once for each underrun.
- R10: Writing 1 to status bit 3 clears the underrun flag. Writing 0 there leaves it unchanged.
- R11: With the external clock selected, `sck_out` stays high. Words shift on falling edges of `sck_in`, most significant bit first, and `sd_out` changes within 3 system cycles of that edge.
- R12: Whenever the block is not busy, `sck_out` and `sd_out` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | WORD_W | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | WORD_W | Registered read data, one cycle after the address |
| sck_in | input | 1 | Shift clock from an external master |
| sck_out | output | 1 | Internally generated shift clock, idles high |
| sd_out | output | 1 | Serial data, idles high |
| irq | output | 1 | One-cycle interrupt request |

## Verification
A register write takes effect on the clock edge that samples it. Read data appears one edge after the address is presented, so the bench reads each register over two falling edges. The internal shift clock moves only on divider ticks, which come every DIV cycles. The bench therefore collects bits at each rising edge of `sck_out` it observes, rather than at fixed cycle numbers. Timing is checked against bounds: rise-to-rise spacing must be exactly 2*DIV, and after a write during the wait the falling clock must appear within DIV falling edges. In external-clock mode the bench holds each `sck_in` level for 8 cycles. That is well beyond the three-cycle path through the synchroniser, the edge detector and the output register, so `sd_out` is sampled just before the rising edge is driven.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_TXB  = 2'd2;

  localparam int C_RUN   = 0;
  localparam int C_ABORT = 1;
  localparam int C_EXT   = 2;

  localparam int S_EMPTY = 0;
  localparam int S_BUSY  = 1;
  localparam int S_SHIFT = 2;
  localparam int S_ERR   = 3;

  typedef enum logic [2:0] {
    ACT_IDLE, ACT_RISE, ACT_SHIFT, ACT_STOP, ACT_LOAD, ACT_UNDER, ACT_WAIT
  } act_e;
endpackage

// File: rtl/stx_clk_src.sv
module stx_clk_src #(
  parameter int DIV    = 4,
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ext_mode,
  input  logic sck_pin,
  output logic step
);
  logic tick;
  logic fall;
  logic [SYNC_N:0] sync_q;

  generate
    if (DIV > 1) begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else if (cnt == CW'(DIV - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(DIV - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else sync_q <= {sync_q[SYNC_N-1:0], sck_pin};
  end

  assign fall = sync_q[SYNC_N] & ~sync_q[SYNC_N-1];
  assign step = ext_mode ? fall : tick;
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              run,
  input  logic              ext_mode,
  input  logic              step,
  input  logic              buf_full,
  input  logic [WORD_W-1:0] buf_data,
  output logic              take,
  output logic              underrun,
  output logic              busy,
  output logic              shifting,
  output logic              sck_out,
  output logic              sd_out
);
  localparam int BW = $clog2(WORD_W);
  localparam logic [BW-1:0] LAST = BW'(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [BW-1:0]     bitcnt;
  logic              at_end;
  act_e              act;

  assign at_end = !shifting || (bitcnt == LAST);

  always_comb begin
    act = ACT_IDLE;
    if (!abort && step) begin
      if (!ext_mode && !sck_out) act = ACT_RISE;
      else if (!at_end)          act = ACT_SHIFT;
      else if (!run)             act = ACT_STOP;
      else if (buf_full)         act = ACT_LOAD;
      else if (ext_mode)         act = ACT_UNDER;
      else                       act = ACT_WAIT;
    end
  end

  assign take     = (act == ACT_LOAD);
  assign underrun = (act == ACT_UNDER);

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      shreg    <= '1;
      bitcnt   <= '0;
      shifting <= 1'b0;
      busy     <= 1'b0;
      sck_out  <= 1'b1;
      sd_out   <= 1'b1;
    end else begin
      if (ext_mode) sck_out <= 1'b1;
      case (act)
        ACT_RISE: sck_out <= 1'b1;
        ACT_SHIFT: begin
          shreg  <= {shreg[WORD_W-2:0], 1'b1};
          sd_out <= shreg[WORD_W-2];
          bitcnt <= bitcnt + 1'b1;
          if (!ext_mode) sck_out <= 1'b0;
        end
        ACT_STOP: begin
          shifting <= 1'b0;
          busy     <= 1'b0;
          sd_out   <= 1'b1;
        end
        ACT_LOAD: begin
          shreg    <= buf_data;
          sd_out   <= buf_data[WORD_W-1];
          bitcnt   <= '0;
          shifting <= 1'b1;
          busy     <= 1'b1;
          if (!ext_mode) sck_out <= 1'b0;
        end
        ACT_UNDER: begin
          shreg    <= '1;
          sd_out   <= 1'b1;
          bitcnt   <= '0;
          shifting <= 1'b1;
          busy     <= 1'b1;
        end
        ACT_WAIT: begin
          shifting <= 1'b0;
          sd_out   <= 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/stx_regs.sv
module stx_regs
  import stx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  input  logic              take,
  input  logic              underrun,
  input  logic              busy,
  input  logic              shifting,
  output logic              abort,
  output logic              run,
  output logic              ext_mode,
  output logic              buf_full,
  output logic [WORD_W-1:0] buf_data,
  output logic              err,
  output logic [WORD_W-1:0] rd_data,
  output logic              irq
);
  logic wr_ctrl, wr_stat, wr_txb;
  logic [WORD_W-1:0] stat_v, ctrl_v, rd_mux;

  assign wr_ctrl = wr_en && (wr_addr == A_CTRL);
  assign wr_stat = wr_en && (wr_addr == A_STAT);
  assign wr_txb  = wr_en && (wr_addr == A_TXB);
  assign abort   = wr_ctrl && wr_data[C_ABORT];

  always_comb begin
    stat_v          = '0;
    stat_v[S_EMPTY] = !buf_full;
    stat_v[S_BUSY]  = busy;
    stat_v[S_SHIFT] = shifting;
    stat_v[S_ERR]   = err;
    ctrl_v          = '0;
    ctrl_v[C_RUN]   = run;
    ctrl_v[C_EXT]   = ext_mode;
    case (rd_addr)
      A_CTRL:  rd_mux = ctrl_v;
      A_STAT:  rd_mux = stat_v;
      A_TXB:   rd_mux = buf_data;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      ext_mode <= 1'b0;
      buf_full <= 1'b0;
      buf_data <= '0;
      err      <= 1'b0;
      irq      <= 1'b0;
      rd_data  <= '0;
    end else begin
      irq     <= take | underrun;
      rd_data <= rd_mux;
      if (abort) begin
        run      <= 1'b0;
        ext_mode <= wr_data[C_EXT];
        buf_full <= 1'b0;
        buf_data <= '0;
        err      <= 1'b0;
      end else begin
        if (wr_ctrl) begin
          run      <= wr_data[C_RUN];
          ext_mode <= wr_data[C_EXT];
        end
        if (take) buf_full <= 1'b0;
        if (wr_txb) begin
          buf_data <= wr_data;
          buf_full <= 1'b1;
        end
        if (wr_stat && wr_data[S_ERR]) err <= 1'b0;
        if (underrun) err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_ser_tx.sv
module sync_ser_tx
  import stx_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV    = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              sck_in,
  output logic              sck_out,
  output logic              sd_out,
  output logic              irq
);
  logic step_w, abort_w, run_w, ext_w, full_w, err_w;
  logic take_w, under_w, busy_w, shift_w;
  logic [WORD_W-1:0] bufd_w;

  stx_clk_src #(.DIV(DIV), .SYNC_N(SYNC_N)) u_clk (
    .clk(clk), .rst(rst), .ext_mode(ext_w), .sck_pin(sck_in), .step(step_w)
  );

  stx_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk(clk), .rst(rst), .abort(abort_w), .run(run_w), .ext_mode(ext_w),
    .step(step_w), .buf_full(full_w), .buf_data(bufd_w), .take(take_w),
    .underrun(under_w), .busy(busy_w), .shifting(shift_w),
    .sck_out(sck_out), .sd_out(sd_out)
  );

  stx_regs #(.WORD_W(WORD_W)) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .take(take_w), .underrun(under_w), .busy(busy_w),
    .shifting(shift_w), .abort(abort_w), .run(run_w), .ext_mode(ext_w),
    .buf_full(full_w), .buf_data(bufd_w), .err(err_w), .rd_data(rd_data),
    .irq(irq)
  );
endmodule

// File: rtl/stx_chk.sv
module stx_chk
  import stx_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [1:0]        wr_addr,
  input logic [WORD_W-1:0] wr_data,
  input logic              sck_out,
  input logic              sd_out,
  input logic              irq,
  input logic              busy,
  input logic              shifting,
  input logic              buf_full,
  input logic              run,
  input logic              ext,
  input logic              err,
  input logic              take,
  input logic              under,
  input logic              abort
);
  a_r12_idle_lines: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (sck_out && sd_out));

  a_r4_clock_parked: assert property (@(posedge clk) disable iff (rst)
    !shifting |-> sck_out);

  a_r11_ext_clock_high: assert property (@(posedge clk) disable iff (rst)
    ext |=> sck_out);

  a_r9_irq_pulse: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  a_r9_take_irq: assert property (@(posedge clk) disable iff (rst)
    take |=> irq);

  a_r8_abort_clears: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && !shifting && sck_out && sd_out && !buf_full && !run && !err));

  a_r2_write_fills: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_TXB) |=> buf_full);

  a_r10_err_clear: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_STAT && wr_data[S_ERR] && !under) |=> !err);

  a_r6_underrun_flag: assert property (@(posedge clk) disable iff (rst)
    under |=> (err && irq));
endmodule

bind sync_ser_tx stx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .sck_out(sck_out), .sd_out(sd_out), .irq(irq), .busy(busy_w),
  .shifting(shift_w), .buf_full(full_w), .run(run_w), .ext(ext_w),
  .err(err_w), .take(take_w), .under(under_w), .abort(abort_w)
);

// File: tb/sim_sync_ser_tx.sv
module sim_sync_ser_tx;
  import stx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DIVB       = 4;
  localparam int N_TAB      = 6;
  localparam logic [15:0] TAB [N_TAB] = '{
    {8'hA5, 8'hA5}, {8'h3C, 8'h3C}, {8'h80, 8'h80},
    {8'h01, 8'h01}, {8'hFF, 8'hFF}, {8'h00, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data;
  logic sck_in = 1'b1;
  logic sck_out, sd_out, irq;

  int checks = 0;
  int errors = 0;

  sync_ser_tx #(.WORD_W(8), .DIV(DIVB), .SYNC_N(2)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sck_in(sck_in),
    .sck_out(sck_out), .sd_out(sd_out), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  int n_rise = 0;
  int irq_cnt = 0;
  int irq_wide = 0;
  logic prev_sck = 1'b1;
  logic prev_irq = 1'b0;
  logic rx_bit [256];
  int   rise_cyc [256];

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (sck_out && !prev_sck && n_rise < 256) begin
        rx_bit[n_rise]   = sd_out;
        rise_cyc[n_rise] = cyc;
        n_rise++;
      end
      if (irq) irq_cnt++;
      if (irq && prev_irq) irq_wide++;
    end
    prev_sck = sck_out;
    prev_irq = irq;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic wait_rises(input int target);
    while (n_rise < target) @(negedge clk);
  endtask

  function automatic logic [7:0] word_at(input int base);
    logic [7:0] w = 8'h00;
    for (int k = 0; k < 8; k++) w = {w[6:0], rx_bit[base + k]};
    return w;
  endfunction

  task automatic ext_byte(output logic [7:0] b);
    b = 8'h00;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); sck_in = 1'b0;
      repeat (8) @(negedge clk);
      b = {b[6:0], sd_out};
      sck_in = 1'b1;
      repeat (7) @(negedge clk);
    end
  endtask

  initial begin
    logic [7:0] v;
    int base, ib, rb, gmin, gmax;
    bit seen;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 / R12: reset state
    rd(A_STAT, v);  chk("R2 reset status", v, 8'h01);
    rd(A_CTRL, v);  chk("R2 reset control", v, 8'h00);
    chk("R12 reset lines", {sck_out, sd_out, irq}, 3'b110);

    // R2: write fills buffer; R8: force stop empties it
    wr(A_TXB, 8'h11);
    rd(A_STAT, v);  chk("R2 empty clears on write", v, 8'h00);
    wr(A_CTRL, 8'h02);
    rd(A_STAT, v);  chk("R8 status after force stop", v, 8'h01);
    rd(A_TXB, v);   chk("R8 buffer after force stop", v, 8'h00);

    // Vector table: R1, R3, R9 burst with internal clock
    base = n_rise;
    ib = irq_cnt;
    wr(A_CTRL, 8'h01);
    for (int i = 0; i < N_TAB; i++) begin
      v = 8'h00;
      while (v[S_EMPTY] !== 1'b1) rd(A_STAT, v);
      wr(A_TXB, TAB[i][15:8]);
    end
    wait_rises(base + 8 * N_TAB);
    for (int i = 0; i < N_TAB; i++)
      chk("R1 msb-first word", word_at(base + 8 * i), TAB[i][7:0]);
    gmin = 1000; gmax = 0;
    for (int i = base + 1; i < base + 8 * N_TAB; i++) begin
      if (rise_cyc[i] - rise_cyc[i-1] < gmin) gmin = rise_cyc[i] - rise_cyc[i-1];
      if (rise_cyc[i] - rise_cyc[i-1] > gmax) gmax = rise_cyc[i] - rise_cyc[i-1];
    end
    chk("R3 min rise spacing", gmin, 2 * DIVB);
    chk("R3 max rise spacing", gmax, 2 * DIVB);

    // R4: automatic wait
    rb = n_rise;
    repeat (20 * DIVB) @(negedge clk);
    chk("R4 no edges while waiting", n_rise, rb);
    chk("R4 lines parked high", {sck_out, sd_out}, 2'b11);
    rd(A_STAT, v);  chk("R4 busy set, not shifting", v, 8'h03);
    chk("R9 one pulse per taken word", irq_cnt - ib, N_TAB);

    // R5: restart within DIV cycles of the write
    base = n_rise;
    wr(A_TXB, 8'hC3);
    seen = (sck_out == 1'b0);
    for (int i = 0; i < DIVB; i++) begin
      @(negedge clk);
      if (sck_out == 1'b0) seen = 1'b1;
    end
    chk("R5 clock restarts", seen, 1'b1);
    rd(A_STAT, v);  chk("R2 empty set after take", v[S_EMPTY], 1'b1);

    // R7: graceful stop with a word waiting
    wr(A_TXB, 8'h5A);
    wr(A_CTRL, 8'h00);
    wait_rises(base + 8);
    repeat (6 * DIVB) @(negedge clk);
    chk("R5 restarted word", word_at(base), 8'hC3);
    chk("R7 nothing after stop", n_rise, base + 8);
    rd(A_STAT, v);  chk("R7 idle with word pending", v, 8'h00);
    chk("R7 lines high", {sck_out, sd_out}, 2'b11);

    // R8: force stop mid-word
    base = n_rise;
    wr(A_CTRL, 8'h01);
    wait_rises(base + 3);
    wr(A_CTRL, 8'h02);
    chk("R8 lines high at once", {sck_out, sd_out}, 2'b11);
    rb = n_rise;
    ib = irq_cnt;
    rd(A_STAT, v);  chk("R8 status cleared", v, 8'h01);
    rd(A_CTRL, v);  chk("R8 run cleared", v, 8'h00);
    rd(A_TXB, v);   chk("R8 buffer cleared", v, 8'h00);
    repeat (8 * DIVB) @(negedge clk);
    chk("R8 no edges after stop", n_rise, rb);
    chk("R8 no irq after stop", irq_cnt, ib);

    // R11: external clock
    wr(A_CTRL, 8'h06);
    wr(A_TXB, 8'h96);
    wr(A_CTRL, 8'h05);
    rb = n_rise;
    ib = irq_cnt;
    ext_byte(v);    chk("R11 external word", v, 8'h96);
    chk("R11 sck_out held high", n_rise, rb);
    rd(A_STAT, v);  chk("R11 status mid-stream", v, 8'h07);

    // R6: underrun
    ext_byte(v);    chk("R6 underrun sends ones", v, 8'hFF);
    rd(A_STAT, v);  chk("R6 error flag set", v, 8'h0F);
    chk("R6 irq for take and underrun", irq_cnt - ib, 2);

    // R10: error clear
    wr(A_STAT, 8'h00);
    rd(A_STAT, v);  chk("R10 writing 0 keeps error", v[S_ERR], 1'b1);
    wr(A_STAT, 8'h08);
    rd(A_STAT, v);  chk("R10 writing 1 clears error", v[S_ERR], 1'b0);

    // R7: graceful stop in external mode
    wr(A_CTRL, 8'h04);
    ext_byte(v);    chk("R7 ext stop line high", v, 8'hFF);
    rd(A_STAT, v);  chk("R7 ext idle status", v, 8'h01);

    chk("R9 irq pulses one cycle", irq_wide, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule